// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Sample Playback Buffer

This block stores 1024 audio samples of 16 bits and plays them out one sample per audio clock. A producer on a separate, much faster clock loads the store through a byte-wide write port. Each sample takes two byte writes: the even byte address holds the low byte and the odd byte address holds the high byte. The store and the two ports are fully independent, so loading and playback can overlap.

Playback is run by a three-state machine on the audio clock. IDLE is the state after reset. RUN is the state in which samples stream out, and HALT is the state after a stop, with the position held. The transitions are as follows. Start moves IDLE to RUN when play is high and stop is low. Stop moves RUN to HALT when stop is high. Resume moves HALT to RUN when play is high and stop is low. A synchronous reset returns every state to IDLE.

A rate input sets the step of the read pointer on each audio clock. The top bit of the pointer is brought out as a half flag, which tells the producer which half is being consumed. A copy of the flag is also synchronized into the producer's clock domain. With it, the producer can refill the idle half while the other half plays (double buffering).

Top module: `pingpong_audio_buf`

## Requirements
- R1: A write with wr_en high stores wr_byte_data at byte address a. Bit 0 of a selects the lane: 0 writes sample bits [7:0] and 1 writes bits [15:8] of sample a>>1.
- R2: rd_rst is synchronous to rd_clk. It forces state IDLE, pointer 0, playing_o 0 and sample_o 0, and it leaves the stored samples unchanged.
- R3: In IDLE or HALT, play_i=1 with stop_i=0 makes playing_o 1 after the next rd_clk edge. stop_i=1 always wins over play_i.
- R4: After a start from reset, sample_o is 0 in the first cycle with playing_o high. In the next cycle it shows stored sample 0.
- R5: At rate_i=1, the pointer advances by one sample per rd_clk in RUN and wraps from 1023 to 0. sample_o shows consecutive samples.
- R6: rate_i=0 holds the pointer, so the same sample repeats. rate_i=2 advances it by two. rate_i=3 behaves as rate 1.
- R7: stop_i=1 in RUN clears playing_o and gives sample_o=0 from the next cycle, with the pointer frozen. A later resume continues with the sample after the last one shown.
- R8: rd_half_o equals the top bit of the read pointer. A value of 1 means the upper half (samples 512 to 1023) is being read.
- R9: wr_half_o is rd_half_o passed through two wr_clk flops. It matches rd_half_o within three wr_clk edges of a change.
- R10: Samples rewritten in the half not being read during playback appear on the next pass through that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_en | input | 1 | Byte write enable |
| wr_byte_addr | input | 11 | Byte address; bit 0 picks low/high byte |
| wr_byte_data | input | 8 | Byte to store |
| wr_half_o | output | 1 | Half flag synchronized to wr_clk |
| rd_clk | input | 1 | Audio sample clock |
| rd_rst | input | 1 | Synchronous reset, audio domain |
| play_i | input | 1 | Start or resume request |
| stop_i | input | 1 | Stop request, dominant |
| rate_i | input | 2 | Step select: 0 hold, 1 normal, 2 double, 3 normal |
| sample_o | output | 16 | Current sample, 0 when not playing |
| playing_o | output | 1 | High in state RUN |
| rd_half_o | output | 1 | Top bit of the read pointer |

## Verification
Playback is tried first with a fully loaded store at normal rate, across more than one wrap. This separates the byte-lane packing, the one-cycle start latency and the wrap point. A stop/resume pattern then shows whether the pointer freezes at the right sample. Stop and play raised together check which request wins. The runs at rates 2, 0 and 3 separate the step decode. A refill of the lower half while the upper half plays, followed by a reset and restart, shows whether new data lands and whether reset leaves the stored samples alone.

// File: rtl/pab_pkg.sv
package pab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } pab_state_e;

    localparam logic [1:0] RATE_HOLD   = 2'd0;
    localparam logic [1:0] RATE_NORMAL = 2'd1;
    localparam logic [1:0] RATE_DOUBLE = 2'd2;
endpackage

// File: rtl/pab_sample_ram.sv
module pab_sample_ram #(
    parameter int DEPTH = 1024,
    parameter int LANES = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(LANES)
) (
    input  logic                 wr_clk,
    input  logic                 wr_en,
    input  logic [AW+LW-1:0]     wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 rd_clk,
    input  logic [AW-1:0]        rd_addr,
    output logic [8*LANES-1:0]   rd_q
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bank [DEPTH];
        always_ff @(posedge wr_clk) begin
            if (wr_en && (wr_addr[LW-1:0] == LW'(g)))
                bank[wr_addr[AW+LW-1:LW]] <= wr_data;
        end
        always_ff @(posedge rd_clk) begin
            rd_q[8*g +: 8] <= bank[rd_addr];
        end
    end
endmodule

// File: rtl/pab_sync2.sv
module pab_sync2 (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic meta_q;
    always_ff @(posedge clk) begin
        meta_q <= d;
        q      <= meta_q;
    end
endmodule

// File: rtl/pab_play_ctrl.sv
module pab_play_ctrl
    import pab_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          play,
    input  logic          stop,
    input  logic [1:0]    rate,
    output logic          playing,
    output logic [AW-1:0] rd_addr,
    output logic          rd_valid
);
    pab_state_e    state_q, state_d;
    logic          advance;
    logic [AW-1:0] step;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!stop && play) state_d = ST_RUN;
            ST_RUN:  if (stop)          state_d = ST_HALT;
            ST_HALT: if (!stop && play) state_d = ST_RUN;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (rate)
            RATE_HOLD:   step = AW'(0);
            RATE_DOUBLE: step = AW'(2);
            default:     step = AW'(1);
        endcase
    end

    assign playing = (state_q == ST_RUN);
    assign advance = playing && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= advance;
            if (advance) rd_addr <= rd_addr + step;
        end
    end

    p_rst_clear_r2: assert property (@(posedge clk)
        rst |=> (rd_addr == '0 && !playing && !rd_valid));
    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        (play && !stop) |=> playing);
    p_stop_wins_r3: assert property (@(posedge clk) disable iff (rst)
        stop |=> !playing);
    p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
        (playing && !stop && rate == RATE_NORMAL) |=> rd_addr == $past(rd_addr) + AW'(1));
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rate == RATE_HOLD) |=> $stable(rd_addr));
    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        !playing |=> $stable(rd_addr));
endmodule

// File: rtl/pingpong_audio_buf.sv
module pingpong_audio_buf #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = 16
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW:0]   wr_byte_addr,
    input  logic [7:0]    wr_byte_data,
    output logic          wr_half_o,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          play_i,
    input  logic          stop_i,
    input  logic [1:0]    rate_i,
    output logic [SW-1:0] sample_o,
    output logic          playing_o,
    output logic          rd_half_o
);
    logic [AW-1:0] rd_addr;
    logic          rd_valid;
    logic [SW-1:0] ram_q;

    pab_sample_ram #(.DEPTH(DEPTH), .LANES(SW/8)) u_ram (
        .wr_clk  (wr_clk),
        .wr_en   (wr_en),
        .wr_addr (wr_byte_addr),
        .wr_data (wr_byte_data),
        .rd_clk  (rd_clk),
        .rd_addr (rd_addr),
        .rd_q    (ram_q)
    );

    pab_play_ctrl #(.AW(AW)) u_ctrl (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .play     (play_i),
        .stop     (stop_i),
        .rate     (rate_i),
        .playing  (playing_o),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid)
    );

    pab_sync2 u_half_sync (
        .clk (wr_clk),
        .d   (rd_half_o),
        .q   (wr_half_o)
    );

    assign rd_half_o = rd_addr[AW-1];
    assign sample_o  = rd_valid ? ram_q : '0;

    p_silent_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !playing_o |=> sample_o == '0);
endmodule

// File: tb/pingpong_audio_buf_tb_top.sv
`timescale 1ns/1ps
module pingpong_audio_buf_tb_top;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_byte_addr = '0;
    logic [7:0]  wr_byte_data = '0;
    logic        wr_half_o;
    logic        rd_rst = 1'b1;
    logic        play_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [1:0]  rate_i = 2'd1;
    logic [15:0] sample_o;
    logic        playing_o;
    logic        rd_half_o;

    int checks = 0;
    int failures = 0;
    logic [15:0] model [1024];

    always #2  wr_clk = ~wr_clk;
    always #20 rd_clk = ~rd_clk;

    pingpong_audio_buf dut_i (.*);

    function automatic logic [15:0] pat_a(int n);
        logic [15:0] v = 16'(n) * 16'h9E37;
        return v ^ 16'h5A5A;
    endfunction
    function automatic logic [15:0] pat_b(int n);
        return ~pat_a(n) ^ 16'(n * 3);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic put_sample(int n, logic [15:0] v);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_byte_addr = 11'(2*n);   wr_byte_data = v[7:0];
        @(negedge wr_clk);
        wr_byte_addr = 11'(2*n+1); wr_byte_data = v[15:8];
        @(negedge wr_clk);
        wr_en = 1'b0;
        model[n] = v;
    endtask

    task automatic do_reset();
        @(negedge rd_clk);
        rd_rst = 1'b1; play_i = 1'b0; stop_i = 1'b0; rate_i = 2'd1;
        @(negedge rd_clk);
        chk("R2 playing", 32'(playing_o), 0);
        chk("R2 sample", 32'(sample_o), 0);
        chk("R2 half", 32'(rd_half_o), 0);
        rd_rst = 1'b0;
    endtask

    task automatic t_linear();
        for (int n = 0; n < 1024; n++) put_sample(n, pat_a(n));
        do_reset();
        play_i = 1'b1;
        @(negedge rd_clk);
        chk("R3 start", 32'(playing_o), 1);
        chk("R4 first cycle zero", 32'(sample_o), 0);
        for (int k = 0; k < 1100; k++) begin
            @(negedge rd_clk);
            chk("R1/R5 sample", 32'(sample_o), 32'(model[k % 1024]));
            chk("R8 half", 32'(rd_half_o), 32'(((k + 1) % 1024) >> 9));
            chk("R9 synced half", 32'(wr_half_o), 32'(rd_half_o));
        end
    endtask

    task automatic t_stop_resume();
        stop_i = 1'b1; play_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge rd_clk);
            chk("R7 stopped", 32'(playing_o), 0);
            chk("R7 zero", 32'(sample_o), 0);
        end
        stop_i = 1'b0; play_i = 1'b1;
        @(negedge rd_clk);
        chk("R3 resume", 32'(playing_o), 1);
        for (int k = 76; k < 80; k++) begin
            @(negedge rd_clk);
            chk("R7 resume pos", 32'(sample_o), 32'(model[k]));
        end
    endtask

    task automatic t_rates();
        do_reset();
        play_i = 1'b1; stop_i = 1'b1;
        @(negedge rd_clk);
        chk("R3 stop wins", 32'(playing_o), 0);
        stop_i = 1'b0; rate_i = 2'd2;
        @(negedge rd_clk);
        chk("R3 start", 32'(playing_o), 1);
        for (int j = 0; j < 5; j++) begin
            @(negedge rd_clk);
            chk("R6 double", 32'(sample_o), 32'(model[2*j]));
        end
        rate_i = 2'd0;
        for (int j = 0; j < 3; j++) begin
            @(negedge rd_clk);
            chk("R6 hold", 32'(sample_o), 32'(model[10]));
        end
        rate_i = 2'd3;
        for (int j = 0; j < 3; j++) begin
            @(negedge rd_clk);
            chk("R6 code3", 32'(sample_o), 32'(model[10 + j]));
        end
        rate_i = 2'd1;
    endtask

    task automatic t_refill();
        do_reset();
        play_i = 1'b1;
        @(negedge rd_clk);
        fork
            begin
                wait (wr_half_o == 1'b1);
                for (int n = 0; n < 512; n++) put_sample(n, pat_b(n));
            end
            begin
                for (int k = 0; k < 1124; k++) begin
                    @(negedge rd_clk);
                    chk("R10 refill", 32'(sample_o), 32'(model[k % 1024]));
                end
            end
        join
        do_reset();
        play_i = 1'b1;
        @(negedge rd_clk);
        @(negedge rd_clk);
        chk("R2 memory kept", 32'(sample_o), 32'(pat_b(0)));
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge rd_clk);
        t_linear();
        t_stop_resume();
        t_rates();
        t_refill();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule